// File: doc/BRIEF.md
# Event-Period Oscillator Trim Controller

This block steers a 6-bit trim code for an on-chip oscillator. It runs a free-running counter from the oscillator's own clock and times an external event whose true period is known, such as a mains-frequency edge. Each rising edge of the event stores the counter value. The gap between two such timestamps is the measured period in oscillator cycles.

When the measured period is too long, the oscillator is running fast, so the trim is lowered by one step. When the period is too short, the oscillator is slow, so the trim is raised by one step. A programmable tolerance band around the expected count stops the trim from moving on small errors. Every timestamp serves as the end of one interval and as the start of the next, so each event after the first yields one measurement.

Top module: `event_period_trim`

## Requirements
- R1: While reset is asserted, and after it is released, trim equals the parameter TRIM_INIT (default 32), period is 0 and period_valid is 0.
- R2: After enable goes high, the first qualified rising edge stores a timestamp only: period_valid stays 0 and trim and period keep their values.
- R3: On each later rising edge, period takes the number of clock cycles since the previous rising edge and period_valid is high for exactly one cycle. This happens three clock edges after event_in is first sampled high. At all other times period holds its value.
- R4: The period is computed modulo 2^CNT_W, so a counter wrap between two edges still gives the true interval for any interval below 2^CNT_W.
- R5: If the measured period is greater than expected_period + tolerance, trim decreases by 1 in the same cycle that period_valid rises.
- R6: If the measured period plus tolerance is less than expected_period, trim increases by 1 in the same cycle that period_valid rises.
- R7: If the measured period lies within the band, edges included, trim is unchanged. A tolerance of 0 leaves the trim unchanged only on an exact match.
- R8: trim saturates: it never goes below 0 or above 63, and it changes by at most one step per measurement.
- R9: The timestamp that ends one interval starts the next, so back-to-back edges give back-to-back measurements.
- R10: While enable is low, event edges produce no measurement and leave trim and period unchanged. The stored timestamp is discarded, so after enable returns high, the first edge only re-seeds (as in R2).
- R11: event_in is synchronised through two flops and only its rising transitions count. A level held high for many cycles produces a single capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock; also clocks the timestamp counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_in | input | 1 | Asynchronous known-period event |
| enable | input | 1 | Allows measurements and trim updates |
| expected_period | input | CNT_W | Expected event period in clock cycles |
| tolerance | input | CNT_W | Half-width of the dead-band in clock cycles |
| trim | output | TRIM_W | Oscillator trim code |
| period | output | CNT_W | Last measured period |
| period_valid | output | 1 | One-cycle strobe marking a new period |

## Verification
The bench uses an 8-bit counter. It sweeps the event interval one cycle at a time across the whole dead-band and past both of its edges. This separates the decrement, hold and increment outcomes and catches off-by-one errors in the band limits. The sweep is repeated with a zero tolerance. Intervals near 255 force counter wraps, and long runs of slow and fast intervals drive the trim into both saturation limits. Level-held pulses, a disable window and re-seeding after re-enable show that only qualified rising edges count.

// File: rtl/event_period_trim.sv
module event_period_trim #(
  parameter int CNT_W     = 16,
  parameter int TRIM_W    = 6,
  parameter int TRIM_INIT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              event_in,
  input  logic              enable,
  input  logic [CNT_W-1:0]  expected_period,
  input  logic [CNT_W-1:0]  tolerance,
  output logic [TRIM_W-1:0] trim,
  output logic [CNT_W-1:0]  period,
  output logic              period_valid
);
  localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};
  localparam logic [TRIM_W-1:0] TRIM_RST = TRIM_W'(TRIM_INIT);

  logic             sync1, sync2, sync3;
  logic [CNT_W-1:0] stamp_cnt, first_ts;
  logic             have_first;

  wire              rise    = sync2 & ~sync3;
  wire              capture = rise & enable;
  wire              measure = capture & have_first;
  wire [CNT_W-1:0]  meas    = stamp_cnt - first_ts;

  wire [CNT_W:0] upper_lim = {1'b0, expected_period} + {1'b0, tolerance};
  wire [CNT_W:0] meas_plus = {1'b0, meas} + {1'b0, tolerance};
  wire too_long  = {1'b0, meas} > upper_lim;
  wire too_short = meas_plus < {1'b0, expected_period};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sync1, sync2, sync3} <= '0;
    else        {sync1, sync2, sync3} <= {event_in, sync1, sync2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stamp_cnt <= '0;
    else        stamp_cnt <= stamp_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      first_ts   <= '0;
      have_first <= 1'b0;
    end else if (!enable) begin
      have_first <= 1'b0;
    end else if (capture) begin
      first_ts   <= stamp_cnt;
      have_first <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      period       <= '0;
      period_valid <= 1'b0;
      trim         <= TRIM_RST;
    end else begin
      period_valid <= measure;
      if (measure) begin
        period <= meas;
        if (too_long && trim != '0)
          trim <= trim - 1'b1;
        else if (too_short && trim != TRIM_MAX)
          trim <= trim + 1'b1;
      end
    end

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    period_valid |=> !period_valid);

  p_period_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !period_valid |-> $stable(period));

  p_trim_on_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trim) |-> period_valid);

  p_trim_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trim) |-> (({1'b0, trim} == {1'b0, $past(trim)} + 1'b1) ||
                        ({1'b0, $past(trim)} == {1'b0, trim} + 1'b1)));

  p_quiet_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !period_valid);
endmodule

// File: tb/event_period_trim_tb.sv
module event_period_trim_tb;
  localparam int CW = 8;
  localparam int TW = 6;

  logic          clk = 0, rst_n = 0, event_in = 0, enable = 0;
  logic [CW-1:0] expected_period = 8'd100, tolerance = 8'd5;
  logic [TW-1:0] trim;
  logic [CW-1:0] period;
  logic          period_valid;

  int  vectors = 0, misses = 0;
  bit  done = 0;
  int  m_trim = 32, m_period = 0, since = 0;
  bit  m_have = 0;

  event_period_trim #(.CNT_W(CW), .TRIM_W(TW), .TRIM_INIT(32)) u_dut (
    .clk, .rst_n, .event_in, .enable, .expected_period, .tolerance,
    .trim, .period, .period_valid);

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Rising edge at the start; high for hi_len cycles; next edge may follow after ivl cycles
  task automatic pulse(int ivl, int hi_len, string req);
    bit meas = 0;
    bit extra = 0;
    if (enable) begin
      if (m_have) begin
        meas = 1;
        m_period = since % 256;
        if (m_period > expected_period + tolerance) begin
          if (m_trim > 0) m_trim--;
        end else if (m_period + tolerance < expected_period) begin
          if (m_trim < 63) m_trim++;
        end
      end
      m_have = 1;
      since = 0;
    end else m_have = 0;
    for (int i = 0; i < ivl; i++) begin
      event_in = (i < hi_len);
      if (i == 3) begin
        chk({req, " valid"}, period_valid, meas);
        chk({req, " period"}, period, m_period);
        chk({req, " trim"}, trim, m_trim);
      end else if (i > 0 && period_valid) extra = 1;
      @(negedge clk);
      since++;
    end
    chk({req, " single strobe R11"}, extra, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 trim", trim, 32);
    chk("R1 period", period, 0);
    chk("R1 valid", period_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 trim after release", trim, 32);
    enable = 1;
    pulse(100, 2, "R2 seed");
    for (int p = 90; p <= 110; p++) pulse(p, 2, "R5 R6 R7 R9 sweep tol5");
    pulse(100, 2, "R7 sweep tail");
    tolerance = 0;
    for (int p = 97; p <= 103; p++) pulse(p, 3, "R7 sweep tol0");
    pulse(100, 2, "R7 tol0 tail");
    tolerance = 5;
    for (int p = 250; p <= 255; p++) pulse(p, 2, "R4 wrap");
    pulse(100, 2, "R4 tail");
    for (int k = 0; k < 40; k++) pulse(200, 2, "R8 low saturation");
    for (int k = 0; k < 70; k++) pulse(40, 2, "R8 high saturation");
    pulse(100, 40, "R11 held level");
    pulse(60, 59, "R11 held level");
    pulse(100, 2, "R11 tail");
    enable = 0;
    for (int k = 0; k < 4; k++) pulse(150, 2, "R10 disabled");
    enable = 1;
    pulse(30, 2, "R10 reseed");
    pulse(100, 2, "R10 reseed");
    pulse(120, 2, "R10 measure");
    pulse(20, 2, "R5 final");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule